// File: doc/BRIEF.md
# Coarse-Fine Time Interval Digitizer

This block measures the time between a start event and a stop event with a resolution finer than one clock period. A free-running cycle counter supplies the coarse part of each event time. The fine part comes from a snapshot of a tapped delay line. That snapshot is registered outside the block on the same clock edge and handed in as a tap word together with a one-cycle event strobe. Each tap word is decoded into the number of taps the event travelled before the sampling edge. That count is merged with the coarse count into a timestamp, and the interval is the stop timestamp minus the start timestamp.

The counter is kept twice: once on the rising edge and once as a falling-edge copy. For each event, the decoded fine code picks which of the two is read, so that the chosen value is never one that is changing near the moment of the event. Tap weights are taken as uniform and equal to one unit. One clock period is `TAPS` units, and `TAPS` must be a power of two.

Top module: `tdc_interval`

## Requirements
- R1: After reset, `interval_vld` is low and `interval` is zero.
- R2: The fine code of a tap word is its number of zero bits, from 0 to `TAPS`. Each zero bit counts wherever it sits, so a bubble (a 1 below a 0) gives the same code as the clean thermometer word with the same number of zeros.
- R3: The coarse count rises by one on every clock. An event presented in cycle C with fine code F has timestamp C*`TAPS` - F, taken modulo 2^`TS_W`, where `TS_W` = `CNT_W` + log2(`TAPS`). Two stops with zero fine code therefore give an interval of exactly d*`TAPS` for d cycles.
- R4: When `stop_stb` is high while a measurement is open, `interval` in the next cycle equals the stop timestamp minus the start timestamp, modulo 2^`TS_W`, and `interval_vld` is high.
- R5: `interval_vld` is high for exactly one cycle per result. `interval` holds its last result until the next result.
- R6: A `stop_stb` when no measurement is open produces no result and leaves `interval` unchanged.
- R7: A `start_stb` always opens a fresh measurement and replaces any start time already held. When both strobes are high in the same cycle, the start is taken and the stop is ignored.
- R8: A fine code greater than `TAPS`/2 reads the falling-edge copy of the counter, and any other code reads the rising-edge counter. Both copies hold the same count at the sampling edge, so results are continuous across the half-period boundary (fine codes `TAPS`/2 and `TAPS`/2+1 differ by one unit).
- R9: An interval that spans the wrap of the `CNT_W`-bit counter is still correct, provided it is shorter than the range 2^`CNT_W` clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_stb | input | 1 | Start event present in this cycle |
| start_taps | input | TAPS | Registered delay-line snapshot for the start event |
| stop_stb | input | 1 | Stop event present in this cycle |
| stop_taps | input | TAPS | Registered delay-line snapshot for the stop event |
| interval | output | TS_W | Stop minus start timestamp, in tap units |
| interval_vld | output | 1 | One-cycle pulse when a new interval is presented |

## Verification
Clean thermometer words are compared with bubbled words of equal zero count, which shows whether the decoder counts zeros or finds the first edge. Fine codes of 0 and `TAPS`, and codes on either side of `TAPS`/2, exercise both counter copies and the extremes of the merge. Sequences with an orphan stop, a double start and simultaneous strobes separate the control rules. A long interval that crosses the counter wrap checks the modular arithmetic.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  // which copy of the coarse counter a timestamp reads
  typedef enum logic {
    CNT_RISE = 1'b0,
    CNT_FALL = 1'b1
  } cnt_src_e;
endpackage

// File: rtl/tdc_fine_decode.sv
module tdc_fine_decode #(
  parameter int TAPS = 32,
  localparam int FW = $clog2(TAPS + 1)
) (
  input  logic [TAPS-1:0] taps,
  output logic [FW-1:0]   zeros
);
  // population count of zero taps, tolerant of bubbles
  always_comb begin
    zeros = '0;
    for (int i = 0; i < TAPS; i++) begin
      zeros = zeros + FW'(~taps[i]);
    end
  end
endmodule

// File: rtl/tdc_coarse.sv
module tdc_coarse #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_rise,
  output logic [CNT_W-1:0] cnt_fall
);
  logic [CNT_W-1:0] rise_d;

  always_comb begin
    rise_d = cnt_rise + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_rise <= '0;
    else        cnt_rise <= rise_d;
  end

  // opposite-phase copy, settled half a period before the next rising edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) cnt_fall <= '0;
    else        cnt_fall <= cnt_rise;
  end

  // R8
  phase_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_fall == cnt_rise);
endmodule

// File: rtl/tdc_stamp.sv
module tdc_stamp
  import tdc_pkg::*;
#(
  parameter int TAPS  = 32,
  parameter int CNT_W = 16,
  localparam int FW   = $clog2(TAPS + 1),
  localparam int LW   = $clog2(TAPS),
  localparam int TS_W = CNT_W + LW
) (
  input  logic [CNT_W-1:0] cnt_rise,
  input  logic [CNT_W-1:0] cnt_fall,
  input  logic [FW-1:0]    fine,
  output logic [TS_W-1:0]  ts
);
  localparam logic [FW-1:0] HALF = FW'(TAPS / 2);

  cnt_src_e         src;
  logic [CNT_W-1:0] coarse;

  always_comb begin
    // early in the period: read the copy that is far from its update
    src    = (fine > HALF) ? CNT_FALL : CNT_RISE;
    coarse = (src == CNT_FALL) ? cnt_fall : cnt_rise;
    ts     = {coarse, {LW{1'b0}}} - TS_W'(fine);
  end
endmodule

// File: rtl/tdc_interval.sv
module tdc_interval #(
  parameter int TAPS  = 32,
  parameter int CNT_W = 16,
  localparam int FW   = $clog2(TAPS + 1),
  localparam int TS_W = CNT_W + $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_stb,
  input  logic [TAPS-1:0] start_taps,
  input  logic            stop_stb,
  input  logic [TAPS-1:0] stop_taps,
  output logic [TS_W-1:0] interval,
  output logic            interval_vld
);
  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_s;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_s <= 2'b00;
    else        rst_s <= {rst_s[0], 1'b1};
  end
  assign rst_int_n = rst_s[1];

  logic [CNT_W-1:0] cnt_rise, cnt_fall;

  tdc_coarse #(.CNT_W(CNT_W)) u_coarse (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cnt_rise (cnt_rise),
    .cnt_fall (cnt_fall)
  );

  // channel 0 = start, channel 1 = stop
  logic [1:0][TAPS-1:0] taps_ch;
  logic [1:0][FW-1:0]   fine_ch;
  logic [1:0][TS_W-1:0] ts_ch;

  assign taps_ch = {stop_taps, start_taps};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    tdc_fine_decode #(.TAPS(TAPS)) u_dec (
      .taps  (taps_ch[ch]),
      .zeros (fine_ch[ch])
    );
    tdc_stamp #(.TAPS(TAPS), .CNT_W(CNT_W)) u_stamp (
      .cnt_rise (cnt_rise),
      .cnt_fall (cnt_fall),
      .fine     (fine_ch[ch]),
      .ts       (ts_ch[ch])
    );
  end

  // control: next state
  logic            armed_q, armed_d;
  logic [TS_W-1:0] start_ts_q;
  logic            start_en, result_en;
  logic [TS_W-1:0] diff;

  always_comb begin
    start_en  = start_stb;
    result_en = stop_stb && !start_stb && armed_q;
    armed_d   = armed_q;
    if (start_en)       armed_d = 1'b1;
    else if (result_en) armed_d = 1'b0;
    diff      = ts_ch[1] - start_ts_q;
  end

  // control: registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      armed_q      <= 1'b0;
      start_ts_q   <= '0;
      interval     <= '0;
      interval_vld <= 1'b0;
    end else begin
      armed_q      <= armed_d;
      interval_vld <= result_en;
      if (start_en)  start_ts_q <= ts_ch[0];
      if (result_en) interval   <= diff;
    end
  end

  // R5
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    interval_vld |=> !interval_vld);
  // R5
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !interval_vld |-> $stable(interval));
  // R6
  orphan_stop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stop_stb && !start_stb && !armed_q) |=> !interval_vld);
  // R4
  vld_cause_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    interval_vld |-> $past(stop_stb && !start_stb && armed_q));
  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_stb |=> (armed_q && !interval_vld));
endmodule

// File: tb/sim_tdc_interval.sv
module sim_tdc_interval;
  localparam int  TAPS   = 32;
  localparam int  CNT_W  = 16;
  localparam int  TS_W   = CNT_W + 5;
  localparam time PERIOD = 10ns;
  localparam longint MOD = longint'(1) << TS_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_stb = 1'b0, stop_stb = 1'b0;
  logic [TAPS-1:0] start_taps = '1, stop_taps = '1;
  logic [TS_W-1:0] interval;
  logic            interval_vld;

  tdc_interval #(.TAPS(TAPS), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .start_stb(start_stb), .start_taps(start_taps),
    .stop_stb(stop_stb), .stop_taps(stop_taps),
    .interval(interval), .interval_vld(interval_vld)
  );

  always #(PERIOD/2) clk = ~clk;

  int     checks = 0, errors = 0;
  string  tag = "R1";
  longint cyc = 0;
  bit     m_armed = 0;
  longint m_scyc = 0, m_sfine = 0;
  bit     exp_vld = 0;
  longint exp_iv = 0;

  function automatic logic [TAPS-1:0] mk(int f, bit bub);
    logic [TAPS:0] one = 1;
    logic [TAPS:0] w;
    w = ~((one << f) - 1);
    if (bub && f >= 2 && f < TAPS) begin
      w[f-2] = 1'b1;
      w[f]   = 1'b0;
    end
    return w[TAPS-1:0];
  endfunction

  task automatic compare();
    checks++;
    if (interval_vld !== exp_vld || interval !== TS_W'(exp_iv)) begin
      errors++;
      $display("FAIL %s cyc %0d: vld=%0b interval=%0d expected vld=%0b interval=%0d",
               tag, cyc, interval_vld, interval, exp_vld, exp_iv);
    end
  endtask

  // one cycle: check outputs, drive inputs, advance the reference model
  task automatic step(bit st, int sf, bit sp, int pf, bit bub = 0);
    @(negedge clk);
    compare();
    start_stb  = st;
    stop_stb   = sp;
    start_taps = st ? mk(sf, bub) : TAPS'(cyc * 32'h9E37_79B9);
    stop_taps  = sp ? mk(pf, bub) : TAPS'(~cyc * 32'h85EB_CA6B);
    exp_vld = 0;
    if (st) begin
      m_armed = 1; m_scyc = cyc; m_sfine = sf;
    end else if (sp && m_armed) begin
      exp_vld = 1;
      exp_iv  = ((cyc - m_scyc) * TAPS - pf + m_sfine) % MOD;
      if (exp_iv < 0) exp_iv += MOD;
      m_armed = 0;
    end
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    checks++;
    if (interval_vld !== 1'b0 || interval !== '0) begin
      errors++;
      $display("FAIL R1 reset: vld=%0b interval=%0d expected vld=0 interval=0",
               interval_vld, interval);
    end
    idle(2);

    tag = "R4"; step(1, 5, 0, 0); idle(9); step(0, 0, 1, 20); idle(2);
    tag = "R3"; step(1, 0, 0, 0); idle(6); step(0, 0, 1, 0); idle(2);
    tag = "R4"; step(1, 0, 0, 0); step(0, 0, 1, 31); idle(2);
    tag = "R2"; step(1, 32, 0, 0); idle(3); step(0, 0, 1, 0); idle(2);
    tag = "R2"; step(1, 11, 0, 0, 1); idle(4); step(0, 0, 1, 27, 1); idle(2);
    tag = "R8"; step(1, 16, 0, 0); idle(2); step(0, 0, 1, 17); idle(2);
    tag = "R8"; step(1, 17, 0, 0); idle(2); step(0, 0, 1, 16); idle(2);
    tag = "R6"; step(0, 0, 1, 9); idle(3);
    tag = "R6"; step(1, 3, 0, 0); step(0, 0, 1, 4); step(0, 0, 1, 6); idle(2);
    tag = "R7"; step(1, 2, 0, 0); idle(5); step(1, 30, 0, 0); idle(3);
    step(0, 0, 1, 8); idle(2);
    tag = "R7"; step(1, 7, 0, 0); idle(2); step(1, 12, 1, 1); idle(2);
    step(0, 0, 1, 25); idle(2);
    tag = "R5"; step(1, 1, 0, 0); step(0, 0, 1, 2); step(1, 4, 0, 0);
    step(0, 0, 1, 4); idle(4);
    tag = "R9"; idle(60000); step(1, 9, 0, 0); idle(10000);
    step(0, 0, 1, 3); idle(3);
    finish_run();
  end
endmodule